// File: doc/BRIEF.md
# Latched Status Register Group

This block collects sixteen live status conditions and turns them into one summary bit for a higher-level status byte. A condition register samples the inputs every clock. Two programmable edge-select registers decide which changes count as events. One selects rising edges per bit, the other falling edges. A selected edge sets the matching bit of a sticky event register. An enable register masks the event register, and the unmasked bits are ORed into a registered summary output.

A host reaches the group through a small register port with single-cycle read and write strobes and 3-bit word addresses. The event register has destructive read semantics: a read returns its contents and empties it in the same access. A preset strobe returns the configuration to its default, a clear strobe empties the event register, and the asynchronous reset does both.

Top module: `stat_group`

## Requirements
- R1: An event bit, once set, stays set until a read of the event register, the clear strobe or reset. Preset does not clear it.
- R2: A read of the event register (address 1) returns its contents and leaves it cleared.
- R3: Reset clears the event register, and so does a one-cycle pulse on clear_i.
- R4: summary_o is the OR over all bits of (event AND enable).
- R5: An enable bit of 0 keeps the matching event bit from raising summary_o.
- R6: A read of the enable register (address 2) does not change it. Reset, preset_i, or a write of zero clears it.
- R7: Reset and preset_i load the rising-edge select (address 3) with all ones and the falling-edge select (address 4) with zero.
- R8: The condition register (address 0) samples cond_i every clock. An event bit sets when its rising select is 1 and the condition went 0 to 1, or when its falling select is 1 and the condition went 1 to 0.
- R9: An event that arrives in the same cycle as a read of the event register stays latched after the read.
- R10: rdata_o is registered: it takes the addressed value one clock after rd_i and holds it otherwise. Writes to addresses 0 and 1 are ignored. Addresses 5 to 7 read as zero.
- R11: summary_o changes one clock after the event or enable contents change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 16 | Live condition inputs, synchronous to clk_i |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one clock after rd_i |
| preset_i | input | 1 | Load the default configuration |
| clear_i | input | 1 | Clear the event register |
| summary_o | output | 1 | Registered masked OR of the event register |

## Verification
The assertions assume that cond_i is already synchronous to clk_i. They also assume that addr_i is valid in any cycle where rd_i or wr_i is high, and that every strobe lasts exactly one cycle. The bench changes all inputs on the falling clock edge and raises only one strobe at a time. The one exception is a read that is deliberately paired with a new condition edge to exercise the coincident case. The bench also holds each condition value for at least one full cycle, so every edge it intends is sampled.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_COND   = 3'd0,
    A_EVENT  = 3'd1,
    A_ENABLE = 3'd2,
    A_RISE   = 3'd3,
    A_FALL   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/stat_xfilter.sv
module stat_xfilter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] rise_sel_i,
  input  logic [W-1:0] fall_sel_i,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_i;
  end

  // edge seen against the previous sample; latched in the same edge the sample updates
  assign hit_o  = (rise_sel_i & cond_i & ~cond_q) | (fall_sel_i & ~cond_i & cond_q);
  assign cond_o = cond_q;
endmodule

// File: rtl/stat_evlatch.sv
module stat_evlatch #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic         rd_clr_i,
  input  logic         clear_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] ev_q;
  logic [W-1:0] kept;

  assign kept = (rd_clr_i || clear_i) ? '0 : ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= kept | hit_i; // new hits survive a clearing access
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/stat_cfgregs.sv
module stat_cfgregs
  import stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              preset_i,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      rise_o,
  output logic [W-1:0]      fall_o
);
  localparam int unsigned NREG = 3;

  // g=0 enable, g=1 rising select, g=2 falling select
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_ENABLE) + g);
    localparam logic [W-1:0]      DEF_VAL = (g == 1) ? {W{1'b1}} : {W{1'b0}};
    logic [W-1:0] q_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q_q <= DEF_VAL;
      else if (preset_i)                   q_q <= DEF_VAL;
      else if (wr_i && addr_i == MY_ADDR)  q_q <= wdata_i;
    end
  end

  assign en_o   = g_reg[0].q_q;
  assign rise_o = g_reg[1].q_q;
  assign fall_o = g_reg[2].q_q;
endmodule

// File: rtl/stat_group.sv
module stat_group
  import stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      cond_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              preset_i,
  input  logic              clear_i,
  output logic              summary_o
);
  logic [W-1:0] cond_w, hit_w, ev_w, en_w, rise_w, fall_w;
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;
  logic         sum_q;
  logic         ev_rd;

  assign ev_rd = rd_i && (addr_i == A_EVENT);

  stat_cfgregs #(.W(W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .preset_i(preset_i),
    .en_o    (en_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  stat_xfilter #(.W(W)) u_xf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (cond_i),
    .rise_sel_i(rise_w),
    .fall_sel_i(fall_w),
    .cond_o    (cond_w),
    .hit_o     (hit_w)
  );

  stat_evlatch #(.W(W)) u_ev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_w),
    .rd_clr_i(ev_rd),
    .clear_i (clear_i),
    .ev_o    (ev_w)
  );

  always_comb begin
    case (addr_i)
      A_COND:   rd_mux = cond_w;
      A_EVENT:  rd_mux = ev_w;
      A_ENABLE: rd_mux = en_w;
      A_RISE:   rd_mux = rise_w;
      A_FALL:   rd_mux = fall_w;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      sum_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rd_mux;
      sum_q <= |(ev_w & en_w);
    end
  end

  assign rdata_o   = rdata_q;
  assign summary_o = sum_q;
endmodule

// File: rtl/stat_group_chk.sv
module stat_group_chk
  import stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              clear_i,
  input logic              preset_i,
  input logic [W-1:0]      hit_i,
  input logic [W-1:0]      ev_i,
  input logic [W-1:0]      en_i,
  input logic [W-1:0]      rise_i,
  input logic [W-1:0]      fall_i,
  input logic [W-1:0]      rdata_o,
  input logic              summary_o
);
  a_r1_event_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(rd_i && addr_i == A_EVENT)) |=> ((ev_i & $past(ev_i)) == $past(ev_i)));

  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_EVENT) |=> ((ev_i & ~$past(hit_i)) == '0));

  a_r3_strobe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ((ev_i & ~$past(hit_i)) == '0));

  a_r9_hit_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((ev_i & $past(hit_i)) == $past(hit_i)));

  a_r7_preset_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> (en_i == '0 && rise_i == {W{1'b1}} && fall_i == '0));

  a_r11_summary_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (summary_o == |($past(ev_i) & $past(en_i))));

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind stat_group stat_group_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .clear_i  (clear_i),
  .preset_i (preset_i),
  .hit_i    (hit_w),
  .ev_i     (ev_w),
  .en_i     (en_w),
  .rise_i   (rise_w),
  .fall_i   (fall_w),
  .rdata_o  (rdata_o),
  .summary_o(summary_o)
);

// File: tb/sim_stat_group.sv
`timescale 1ns/1ps
module sim_stat_group;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] cond_i = '0;
  logic         wr_i = 1'b0, rd_i = 1'b0, preset_i = 1'b0, clear_i = 1'b0;
  logic [2:0]   addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         summary_o;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;
  bit           done = 1'b0;

  always #5 clk_i = ~clk_i;

  stat_group #(.W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .preset_i(preset_i),
    .clear_i(clear_i), .summary_o(summary_o)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data the clock after each read strobe
  always @(posedge clk_i) rd_seen <= rd_i;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) begin
      automatic logic [W-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, rdata_o, e);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string t);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic set_cond(input logic [W-1:0] v);
    @(negedge clk_i); cond_i = v;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    check("R3 reset summary", W'(summary_o), '0);
    check("R10 reset rdata", rdata_o, '0);
    rd(3'd3, 16'hFFFF, "R7 reset rise select");
    rd(3'd4, 16'h0000, "R7 reset fall select");
    rd(3'd2, 16'h0000, "R6 reset enable");
    rd(3'd1, 16'h0000, "R3 reset event");

    // rising edges latch by default
    set_cond(16'h0005);
    rd(3'd0, 16'h0005, "R8 condition sample");
    rd(3'd1, 16'h0005, "R2 event read value");
    rd(3'd1, 16'h0000, "R2 event cleared by read");
    check("R5 masked summary", W'(summary_o), '0);
    set_cond(16'h0000);
    rd(3'd1, 16'h0000, "R8 falling ignored by default");

    // falling-edge selection only
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0003);
    set_cond(16'h0003);
    rd(3'd1, 16'h0000, "R8 rise not selected");
    set_cond(16'h0000);
    rd(3'd1, 16'h0003, "R8 fall selected");
    rd(3'd1, 16'h0000, "R2 cleared again");

    // sticky
    wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'h0000);
    set_cond(16'h0010);
    set_cond(16'h0000);
    step(5);
    rd(3'd1, 16'h0010, "R1 event stays latched");

    // summary and masking
    wr(3'd2, 16'h0100);
    set_cond(16'h0100);
    step(1);
    check("R11 summary lags event", W'(summary_o), '0);
    step(1);
    check("R4 summary raised", W'(summary_o), 16'h0001);
    rd(3'd2, 16'h0100, "R6 enable read");
    rd(3'd2, 16'h0100, "R6 enable read non-destructive");
    wr(3'd2, 16'h0000);
    check("R11 summary lags enable", W'(summary_o), 16'h0001);
    step(1);
    check("R6 write zero masks", W'(summary_o), '0);
    wr(3'd2, 16'h0200);
    step(1);
    check("R5 other bit enabled only", W'(summary_o), '0);
    wr(3'd2, 16'h0300);
    step(1);
    check("R4 summary with mixed enable", W'(summary_o), 16'h0001);

    // preset
    wr(3'd3, 16'h00FF);
    wr(3'd4, 16'hFF00);
    @(negedge clk_i); preset_i = 1'b1;
    @(negedge clk_i); preset_i = 1'b0;
    step(1);
    check("R6 preset clears enable", W'(summary_o), '0);
    rd(3'd2, 16'h0000, "R6 enable after preset");
    rd(3'd3, 16'hFFFF, "R7 rise select after preset");
    rd(3'd4, 16'h0000, "R7 fall select after preset");
    rd(3'd1, 16'h0100, "R1 preset keeps event");

    // clear strobe
    set_cond(16'h0101);
    set_cond(16'h0100);
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    rd(3'd1, 16'h0000, "R3 clear strobe");

    // new event coincident with a clearing read
    set_cond(16'h0102);
    @(negedge clk_i);
    cond_i = 16'h0106; rd_i = 1'b1; addr_i = 3'd1;
    exp_q.push_back(16'h0002); tag_q.push_back("R9 read before coincident hit");
    @(negedge clk_i); rd_i = 1'b0;
    rd(3'd1, 16'h0004, "R9 coincident hit kept");

    // register map edges
    wr(3'd1, 16'hFFFF);
    wr(3'd0, 16'hFFFF);
    rd(3'd1, 16'h0000, "R10 event write ignored");
    rd(3'd0, 16'h0106, "R10 condition write ignored");
    step(2);
    check("R10 rdata holds", rdata_o, 16'h0106);
    rd(3'd5, 16'h0000, "R10 unmapped 5");
    rd(3'd7, 16'h0000, "R10 unmapped 7");

    step(2);
    done = 1'b1;
    report();
  end
endmodule